// File: doc/BRIEF.md
# Flash Page-Erase and Halfword-Program Sequencer with Interrupt Abort

This block runs the two slow write operations of an embedded flash array: erasing a whole 512-byte page and programming a single 16-bit halfword. A one-cycle command pulse starts an operation. The pulse carries the operation type, a halfword address and the write data. The sequencer then drives level signals to the flash macro and times the operation with a cycle counter. Both durations are derived from a clock-frequency parameter: an erase lasts 20 ms and a program lasts 50 µs. For the whole operation it raises `busy`, which the fetch and load paths use to stall any flash access.

An interrupt can cut the operation short. When `abort_en` is high and an enabled interrupt (`irq`) is seen during an erase or program, the sequencer stops driving the operation. It then spends a fixed 10-cycle abort phase before it releases the array. It reports `aborted` instead of `done`. The cell contents are then undefined and software must reissue the command. A command that arrives while the sequencer is not idle is dropped and raises `err`. All three status flags are cleared by the next command that is accepted.

Command and status are plain control pins. No data streams through the block, so there is no valid/ready handshake and no back-pressure. A command pulse is either accepted (sequencer idle) or dropped with `err`; it is never held.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `aborted`, `err`, `fl_erase`, `fl_prog`, `fl_abort` and `fl_commit` are all 0.
- R2: An accepted command with `cmd_erase`=1 holds `fl_erase` high for exactly CLK_HZ/50 cycles, starting the cycle after the pulse. `fl_page` equals `cmd_addr[ADDR_W-1:8]` (256 halfwords per page). `fl_commit` pulses in the last cycle, after which every halfword of that page reads 0xFFFF and other pages are unchanged.
- R3: An accepted command with `cmd_erase`=0 holds `fl_prog` high for exactly CLK_HZ/20000 cycles with `fl_addr`=`cmd_addr` and `fl_wdata`=`cmd_data`. `fl_commit` pulses in the last cycle, after which the halfword holds old AND new data and other halfwords are unchanged.
- R4: `busy` is high in every cycle of an erase, a program and an abort phase, and low otherwise.
- R5: On a natural finish, `done` is 1 and `aborted` is 0 from the cycle in which `busy` falls.
- R6: With `abort_en`=1, `irq` high during an erase or program ends it at the next edge. `fl_erase`/`fl_prog` drop and `fl_abort` plus `busy` stay high for exactly 10 cycles. No `fl_commit` occurs. Then `aborted`=1 and `done`=0.
- R7: With `abort_en`=0, `irq` has no effect and the operation runs for its full duration and ends with `done`.
- R8: A `cmd_start` while the sequencer is busy or in its one-cycle done phase is ignored (no macro activity, array unchanged) and sets `err`. The next accepted command clears `done`, `aborted` and `err`.
- R9: `irq` while idle has no effect: `busy` and `aborted` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle command pulse |
| cmd_erase | input | 1 | 1 = page erase, 0 = halfword program |
| cmd_addr | input | ADDR_W | Halfword address (page taken from the upper bits) |
| cmd_data | input | 16 | Program data |
| abort_en | input | 1 | Allows an interrupt to abort an operation |
| irq | input | 1 | Enabled-interrupt indication |
| busy | output | 1 | Stall for flash fetch and data access |
| done | output | 1 | Last operation finished normally |
| aborted | output | 1 | Last operation was aborted; reissue needed |
| err | output | 1 | A command was dropped because the block was not idle |
| fl_erase | output | 1 | Macro erase drive |
| fl_prog | output | 1 | Macro program drive |
| fl_abort | output | 1 | Macro abort/recovery phase |
| fl_commit | output | 1 | Final cycle of a completed erase or program |
| fl_page | output | ADDR_W-8 | Page being erased |
| fl_addr | output | ADDR_W | Halfword being programmed |
| fl_wdata | output | 16 | Data being programmed |

## Verification
A wrong state or a mis-loaded counter shows up as a `busy` window of the wrong length. It also shows up as `done` and `aborted` disagreeing with how the operation ended, so each test counts `busy` cycles and compares them with the derived durations to the exact cycle. A missing or stray `fl_commit` corrupts the bench's array model and is caught when the page or halfword is read back just after `busy` falls. Lost command filtering shows as a changed array or a busy window that restarts, visible within one operation time.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_PROG  = 3'd2,
    ST_ABORT = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  localparam int HW_BITS    = 16;
  localparam int PAGE_BYTES = 512;
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES / 2);
endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_cmdreg.sv
module flash_seq_cmdreg #(
  parameter int ADDR_W = 15,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DW-1:0]     data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DW-1:0]     data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int TW        = 8,
  parameter int ERASE_CYC = 100,
  parameter int PROG_CYC  = 10,
  parameter int ABORT_CYC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_erase,
  input  logic          abort_en,
  input  logic          irq,
  input  logic          t_zero,
  output seq_state_t    state,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          accept,
  output logic          commit,
  output logic          abort_end
);
  seq_state_t state_d;
  logic       op_run, abort_hit;

  assign op_run    = (state == ST_ERASE) || (state == ST_PROG);
  assign abort_hit = op_run && abort_en && irq;

  always_comb begin
    state_d = state;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_start) begin
        accept  = 1'b1;
        t_load  = 1'b1;
        t_val   = cmd_erase ? TW'(ERASE_CYC - 1) : TW'(PROG_CYC - 1);
        state_d = cmd_erase ? ST_ERASE : ST_PROG;
      end
      ST_ERASE, ST_PROG: begin
        if (abort_hit) begin
          t_load  = 1'b1;
          t_val   = TW'(ABORT_CYC - 1);
          state_d = ST_ABORT;
        end else if (t_zero) begin
          state_d = ST_DONE;
        end
      end
      ST_ABORT: if (t_zero) state_d = ST_IDLE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign commit    = op_run && t_zero && !abort_hit;
  assign abort_end = (state == ST_ABORT) && t_zero;
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int ADDR_W    = 15,
  parameter int ABORT_CYC = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_start,
  input  logic                         cmd_erase,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic [HW_BITS-1:0]           cmd_data,
  input  logic                         abort_en,
  input  logic                         irq,
  output logic                         busy,
  output logic                         done,
  output logic                         aborted,
  output logic                         err,
  output logic                         fl_erase,
  output logic                         fl_prog,
  output logic                         fl_abort,
  output logic                         fl_commit,
  output logic [ADDR_W-PAGE_SHIFT-1:0] fl_page,
  output logic [ADDR_W-1:0]            fl_addr,
  output logic [HW_BITS-1:0]           fl_wdata
);
  localparam int ERASE_CYC = CLK_HZ / 50;
  localparam int PROG_CYC  = CLK_HZ / 20000;
  localparam int MAX_CYC   = (ERASE_CYC > ABORT_CYC) ? ERASE_CYC : ABORT_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);

  seq_state_t          state;
  logic                t_load, t_zero, accept, abort_end;
  logic [TW-1:0]       t_val;
  logic [ADDR_W-1:0]   addr_q;
  logic [HW_BITS-1:0]  data_q;

  flash_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  flash_seq_fsm #(
    .TW(TW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .ABORT_CYC(ABORT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_erase(cmd_erase),
    .abort_en(abort_en), .irq(irq), .t_zero(t_zero), .state(state),
    .t_load(t_load), .t_val(t_val), .accept(accept), .commit(fl_commit),
    .abort_end(abort_end)
  );

  flash_seq_cmdreg #(.ADDR_W(ADDR_W), .DW(HW_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .capture(accept), .addr_in(cmd_addr),
    .data_in(cmd_data), .addr_q(addr_q), .data_q(data_q)
  );

  // status flags: cleared by an accepted command, set by the outcome
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      aborted <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (accept) begin
        done    <= 1'b0;
        aborted <= 1'b0;
        err     <= 1'b0;
      end else if (cmd_start) begin
        err     <= 1'b1;
      end
      if (fl_commit) done    <= 1'b1;
      if (abort_end) aborted <= 1'b1;
    end
  end

  assign fl_erase = (state == ST_ERASE);
  assign fl_prog  = (state == ST_PROG);
  assign fl_abort = (state == ST_ABORT);
  assign busy     = fl_erase | fl_prog | fl_abort;
  assign fl_page  = addr_q[ADDR_W-1:PAGE_SHIFT];
  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int ABORT_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic abort_en,
  input logic irq,
  input logic busy,
  input logic done,
  input logic aborted,
  input logic err,
  input logic fl_erase,
  input logic fl_prog,
  input logic fl_abort,
  input logic fl_commit
);
  localparam int ERASE_CYC = CLK_HZ / 50;
  localparam int PROG_CYC  = CLK_HZ / 20000;

  int er_len, pg_len, ab_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_len <= 0; pg_len <= 0; ab_len <= 0;
    end else begin
      er_len <= fl_erase ? er_len + 1 : 0;
      pg_len <= fl_prog  ? pg_len + 1 : 0;
      ab_len <= fl_abort ? ab_len + 1 : 0;
    end
  end

  a_r2_erase_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_erase) && !fl_abort) |-> (er_len == ERASE_CYC));

  a_r3_prog_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_prog) && !fl_abort) |-> (pg_len == PROG_CYC));

  a_r5_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
    fl_commit |=> (done && !aborted && !busy));

  a_r6_abort_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_abort) |-> (ab_len == ABORT_CYC && aborted && !done));

  a_r6_abort_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    fl_abort |-> !fl_commit);

  a_r7_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_abort) |-> $past(abort_en && irq));

  a_r8_busy_cmd_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && busy) |=> err);

  a_r4_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fl_erase, fl_prog, fl_abort}) <= 1);
endmodule

bind flash_seq_top flash_seq_chk #(.CLK_HZ(CLK_HZ), .ABORT_CYC(ABORT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .abort_en(abort_en),
  .irq(irq), .busy(busy), .done(done), .aborted(aborted), .err(err),
  .fl_erase(fl_erase), .fl_prog(fl_prog), .fl_abort(fl_abort),
  .fl_commit(fl_commit)
);

// File: tb/tb_flash_seq_top.sv
module tb_flash_seq_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int AW     = 10;
  localparam int ECYC   = CLK_HZ / 50;
  localparam int PCYC   = CLK_HZ / 20000;
  localparam int ACYC   = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_erase = 0, abort_en = 0, irq = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic busy, done, aborted, err, fl_erase, fl_prog, fl_abort, fl_commit;
  logic [AW-9:0] fl_page;
  logic [AW-1:0] fl_addr;
  logic [15:0] fl_wdata;

  logic [15:0] mem [1 << AW];
  int commits = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_seq_top #(.CLK_HZ(CLK_HZ), .ADDR_W(AW), .ABORT_CYC(ACYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_erase(cmd_erase),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .abort_en(abort_en), .irq(irq),
    .busy(busy), .done(done), .aborted(aborted), .err(err),
    .fl_erase(fl_erase), .fl_prog(fl_prog), .fl_abort(fl_abort),
    .fl_commit(fl_commit), .fl_page(fl_page), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata)
  );

  // flash array model driven by the macro interface
  always @(posedge clk) begin
    if (fl_commit) begin
      commits <= commits + 1;
      if (fl_erase)
        for (int i = 0; i < 256; i++) mem[{fl_page, 8'(i)}] <= 16'hFFFF;
      else if (fl_prog)
        mem[fl_addr] <= mem[fl_addr] & fl_wdata;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic issue(bit er, int addr, int data);
    @(negedge clk);
    cmd_start = 1; cmd_erase = er; cmd_addr = AW'(addr); cmd_data = 16'(data);
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 flags", {done, aborted, err}, 0);
    check("R1 macro", {fl_erase, fl_prog, fl_abort, fl_commit}, 0);
  endtask

  task automatic t_erase(int page);
    int cnt = 0, c0 = commits;
    logic [15:0] other = mem[((page + 1) % 4) * 256 + 7];
    issue(1, page * 256 + 5, 0);
    check("R2 fl_page", int'(fl_page), page);
    check("R2 fl_erase", fl_erase, 1);
    while (busy) begin cnt++; @(negedge clk); end
    check("R2/R4 erase busy cycles", cnt, ECYC);
    check("R5 done/aborted/err", {done, aborted, err}, 3'b100);
    check("R2 one commit", commits - c0, 1);
    check("R2 page first", mem[page * 256], 16'hFFFF);
    check("R2 page last", mem[page * 256 + 255], 16'hFFFF);
    check("R2 other page", mem[((page + 1) % 4) * 256 + 7], other);
    @(negedge clk);
  endtask

  task automatic t_prog(int addr, int data);
    int cnt = 0;
    logic [15:0] exp = mem[addr] & 16'(data);
    logic [15:0] nb = mem[addr ^ 1];
    issue(0, addr, data);
    check("R3 fl_prog", fl_prog, 1);
    check("R3 fl_addr", int'(fl_addr), addr);
    check("R3 fl_wdata", int'(fl_wdata), data);
    while (busy) begin cnt++; @(negedge clk); end
    check("R3/R4 prog busy cycles", cnt, PCYC);
    check("R5 done", {done, aborted, err}, 3'b100);
    check("R3 AND data", mem[addr], exp);
    check("R3 neighbour", mem[addr ^ 1], nb);
    @(negedge clk);
  endtask

  task automatic t_abort(bit er, int k);
    int cnt = 0, c0 = commits;
    abort_en = 1;
    issue(er, 2 * 256 + 9, 16'h00F0);
    while (busy) begin
      cnt++;
      if (cnt == k + 1) check("R6 abort drive", {fl_erase, fl_prog, fl_abort}, 3'b001);
      irq = (cnt == k);
      @(negedge clk);
    end
    irq = 0;
    check("R6/R4 abort busy cycles", cnt, k + ACYC);
    check("R6 flags", {done, aborted}, 2'b01);
    check("R6 no commit", commits - c0, 0);
    abort_en = 0;
    @(negedge clk);
  endtask

  task automatic t_noabort();
    int cnt = 0;
    abort_en = 0;
    issue(0, 3 * 256 + 1, 16'h0FFF);
    while (busy) begin cnt++; irq = cnt[0]; @(negedge clk); end
    irq = 0;
    check("R7 full duration", cnt, PCYC);
    check("R7 done", {done, aborted}, 2'b10);
    @(negedge clk);
  endtask

  task automatic t_reject();
    int cnt = 0, c0;
    logic [15:0] pg = mem[1 * 256 + 3];
    issue(0, 3 * 256 + 2, 16'h1234);
    while (busy) begin
      cnt++;
      if (cnt == 10) begin cmd_start = 1; cmd_erase = 1; cmd_addr = AW'(256 + 3); end
      else cmd_start = 0;
      @(negedge clk);
    end
    check("R8 busy not restarted", cnt, PCYC);
    check("R8 err set", err, 1);
    check("R8 page untouched", mem[1 * 256 + 3], pg);
    // busy just fell: sequencer is in its done phase
    c0 = commits;
    cmd_start = 1; cmd_erase = 0; cmd_addr = AW'(5); cmd_data = 16'h0;
    @(negedge clk);
    cmd_start = 0;
    check("R8 done-phase cmd dropped", busy, 0);
    @(negedge clk);
    check("R8 still idle", busy, 0);
    check("R8 no commit", commits - c0, 0);
    issue(0, 3 * 256 + 4, 16'hFFFF);
    check("R8 flags cleared", {done, aborted, err}, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_idle_irq();
    abort_en = 1;
    irq = 1;
    @(negedge clk);
    @(negedge clk);
    irq = 0;
    check("R9 idle irq busy", busy, 0);
    check("R9 idle irq aborted", aborted, 0);
    abort_en = 0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'(i * 37 + 5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_irq();
    t_erase(0);
    t_prog(4, 16'hA5C3);
    t_prog(4, 16'h0FF0);
    t_prog(300, 16'h5555);
    t_abort(1, 100);
    t_abort(0, 7);
    t_noabort();
    t_reject();
    t_erase(3);
    finish_up();
  end
endmodule